// File: doc/BRIEF.md
# UART Line Status Tracker

This block holds the line status of a UART with a receive FIFO. Each received character arrives as a one-cycle strobe carrying its data byte and two error tags, one for a parity error and one for a framing error. The character goes into a 16-entry receive FIFO, and its tags travel with it. The block also watches the raw receive line. When the line stays low for longer than one configured character time, counted in bit-clock ticks, it queues a single zero character tagged as a break. From the transmit side it takes the holding-FIFO and shift-register empty levels and a strobe that marks the last holding word moving into the shifter.

The CPU sees an 8-bit status byte, zero-extended to 32 bits, with these bits:

| Bit | Meaning |
|-----|---------|
| 7 | FIFO error summary |
| 6 | transmitter empty |
| 5 | holding register empty |
| 4 | break |
| 3 | framing error |
| 2 | parity error |
| 1 | overrun |
| 0 | data ready |

A status read strobe applies the clear-on-read side effects. The FIFO error summary bit is sticky. It survives a status read for as long as any tagged entry is still queued. The transmit-holding-empty interrupt is the holding-empty bit gated by its enable input.

Top module: `uart_line_status`

## Requirements
- R1: `statusWord[31:8]` always reads 0. After reset, with both transmit empty inputs at 1, the word is 0x60 (bits 6 and 5 set).
- R2: Bit 0 (data ready) is 1 whenever the receive FIFO holds an entry. `rxDataOut` shows the oldest entry, and entries leave in arrival order through `rxPop`. The FIFO holds 16 entries.
- R3: Bit 7 sets when an entry with any tag (parity, framing or break) is queued. A status read clears it only if no tagged entry remains queued after that read. Otherwise it stays 1.
- R4: Bit 2 (parity) and bit 3 (framing) show the tags of the head entry. A status read hides them until the next pop brings a new head.
- R5: A character that arrives while the FIFO is full, with no pop in the same cycle, is dropped and sets bit 1 (overrun). A status read clears bit 1.
- R6: With `rxLine` low, the tick that is one more than the character time in bit ticks does three things: it sets bit 4 (break), it queues one 0x00 entry carrying the break tag, and it disarms detection. A status read clears bit 4.
- R7: After a break, detection stays disarmed while the line stays low. It re-arms only once `rxLine` returns to 1.
- R8: Character time = 1 + (5 + `cfgDataLen`) + `cfgParityEn` + (`cfgStop2` ? 2 : 1) bit ticks.
- R9: Bit 6 (transmitter empty) is 1 exactly when both `txFifoEmpty` and `txShiftEmpty` are 1.
- R10: Bit 5 (holding empty) is 1 after reset. It sets one cycle after `txLastMove` and clears one cycle after `thrWrite`. If both arrive in the same cycle, the write wins.
- R11: `thrIrq` equals bit 5 AND `ierThreEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| rxPush | input | 1 | received character strobe |
| rxData | input | 8 | received character |
| rxParErr | input | 1 | parity tag of the character |
| rxFrmErr | input | 1 | framing tag of the character |
| rxPop | input | 1 | CPU reads the FIFO head |
| rxDataOut | output | 8 | FIFO head data |
| rxLine | input | 1 | raw receive line level |
| bitTick | input | 1 | bit-clock tick |
| cfgDataLen | input | 2 | data bits minus 5 |
| cfgParityEn | input | 1 | parity bit present |
| cfgStop2 | input | 1 | two stop bits |
| txFifoEmpty | input | 1 | transmit holding FIFO empty |
| txShiftEmpty | input | 1 | transmit shift register empty |
| txLastMove | input | 1 | last holding word moved to shifter |
| thrWrite | input | 1 | CPU writes holding register |
| ierThreEn | input | 1 | holding-empty interrupt enable |
| statusRead | input | 1 | CPU reads status |
| statusWord | output | 32 | status word |
| thrIrq | output | 1 | holding-empty interrupt |

## Verification
The flags and FIFO state are registered, so a push, pop, tick, read or transmit strobe shows on `statusWord` and `rxDataOut` one cycle after the edge that takes it. The transmitter-empty bit follows its inputs in the same cycle. The bench drives each strobe for exactly one cycle, 1 ns after a rising edge, and samples 1 ns after the next edge. A status value is captured before the read strobe is issued, which matches a CPU seeing the pre-clear value. The break tests step the line one tick at a time so that the single tick where detection fires is checked on both sides.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxTag_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    rxTag_t            tag;
  } rxEntry_t;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [DATA_W-1:0] wrData;
    rxTag_t            wrTag;
  } fifoCmd_t;
endpackage

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  output logic [DATA_W-1:0] headData,
  output rxTag_t            headTag,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     taggedCnt,
  output logic              full,
  output logic              empty
);
  rxEntry_t      mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          tagIn, tagOut;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign headData = mem[rdPtr].data;
  assign headTag  = empty ? rxTag_t'('0) : mem[rdPtr].tag;
  assign tagIn    = cmd.wr && (|cmd.wrTag);
  assign tagOut   = cmd.rd && (|headTag);

  always_ff @(posedge clk) begin
    if (cmd.wr) mem[wrPtr] <= '{data: cmd.wrData, tag: cmd.wrTag};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      taggedCnt <= '0;
    end else begin
      if (cmd.wr) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (cmd.rd) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count     <= count + CW'(cmd.wr) - CW'(cmd.rd);
      taggedCnt <= taggedCnt + CW'(tagIn) - CW'(tagOut);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wr && full) |-> cmd.rd); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rd |-> !empty); // R2
  AST_TAG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    taggedCnt <= count); // R3
endmodule

// File: rtl/lsr_control.sv
module lsr_control
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              rxPop,
  input  logic              rxLine,
  input  logic              bitTick,
  input  logic [1:0]        cfgDataLen,
  input  logic              cfgParityEn,
  input  logic              cfgStop2,
  input  logic              txFifoEmpty,
  input  logic              txShiftEmpty,
  input  logic              txLastMove,
  input  logic              thrWrite,
  input  logic              ierThreEn,
  input  logic              statusRead,
  input  rxTag_t            headTag,
  input  logic [CW-1:0]     taggedCnt,
  input  logic              full,
  input  logic              empty,
  output fifoCmd_t          cmd,
  output logic [7:0]        statusByte,
  output logic              thrIrq
);
  logic [LW-1:0] charBits, lowCnt;
  logic          brkArmed, brkDet, wrReq, overrun, tagIn, tagOut;
  logic          errSum, ovrFlag, brkFlag, headAck, threFlag;

  // character time in bit ticks
  assign charBits = LW'(1) + LW'(5) + LW'(cfgDataLen) + LW'(cfgParityEn)
                  + (cfgStop2 ? LW'(2) : LW'(1));
  assign brkDet   = bitTick && !rxLine && brkArmed && (lowCnt == charBits);

  assign wrReq      = brkDet || rxPush;
  assign overrun    = wrReq && full && !rxPop;
  assign cmd.rd     = rxPop && !empty;
  assign cmd.wr     = wrReq && !overrun;
  assign cmd.wrData = brkDet ? '0 : rxData;
  assign cmd.wrTag  = brkDet ? '{brk: 1'b1, frm: 1'b0, par: 1'b0}
                             : '{brk: 1'b0, frm: rxFrmErr, par: rxParErr};
  assign tagIn      = cmd.wr && (|cmd.wrTag);
  assign tagOut     = cmd.rd && (|headTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt   <= '0;
      brkArmed <= 1'b1;
    end else begin
      if (rxLine) lowCnt <= '0;
      else if (bitTick && lowCnt != '1) lowCnt <= lowCnt + 1'b1;
      if (rxLine) brkArmed <= 1'b1;
      else if (brkDet) brkArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errSum   <= 1'b0;
      ovrFlag  <= 1'b0;
      brkFlag  <= 1'b0;
      headAck  <= 1'b0;
      threFlag <= 1'b1;
    end else begin
      if (tagIn) errSum <= 1'b1;
      else if (statusRead && taggedCnt == CW'(tagOut)) errSum <= 1'b0;

      if (overrun) ovrFlag <= 1'b1;
      else if (statusRead) ovrFlag <= 1'b0;

      if (brkDet) brkFlag <= 1'b1;
      else if (statusRead) brkFlag <= 1'b0;

      if (cmd.rd) headAck <= 1'b0;
      else if (statusRead && !empty) headAck <= 1'b1;

      if (thrWrite) threFlag <= 1'b0;
      else if (txLastMove) threFlag <= 1'b1;
    end
  end

  assign statusByte = {errSum, txFifoEmpty && txShiftEmpty, threFlag, brkFlag,
                       headTag.frm && !headAck, headTag.par && !headAck,
                       ovrFlag, !empty};
  assign thrIrq     = threFlag && ierThreEn;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && taggedCnt > CW'(tagOut)) |=> statusByte[7]); // R3
  AST_BRK_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    brkDet |=> !brkDet); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> statusByte[1]); // R5
  AST_THRE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> !statusByte[5]); // R10
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxPush,
  input  logic [7:0]  rxData,
  input  logic        rxParErr,
  input  logic        rxFrmErr,
  input  logic        rxPop,
  output logic [7:0]  rxDataOut,
  input  logic        rxLine,
  input  logic        bitTick,
  input  logic [1:0]  cfgDataLen,
  input  logic        cfgParityEn,
  input  logic        cfgStop2,
  input  logic        txFifoEmpty,
  input  logic        txShiftEmpty,
  input  logic        txLastMove,
  input  logic        thrWrite,
  input  logic        ierThreEn,
  input  logic        statusRead,
  output logic [31:0] statusWord,
  output logic        thrIrq
);
  fifoCmd_t      cmd;
  rxTag_t        headTag;
  logic [CW-1:0] count, taggedCnt;
  logic          full, empty;
  logic [7:0]    statusByte;

  lsr_datapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .headData(rxDataOut), .headTag(headTag),
    .count(count), .taggedCnt(taggedCnt), .full(full), .empty(empty)
  );

  lsr_control #(.DEPTH(DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rxPop(rxPop), .rxLine(rxLine),
    .bitTick(bitTick), .cfgDataLen(cfgDataLen), .cfgParityEn(cfgParityEn),
    .cfgStop2(cfgStop2), .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty),
    .txLastMove(txLastMove), .thrWrite(thrWrite), .ierThreEn(ierThreEn),
    .statusRead(statusRead), .headTag(headTag), .taggedCnt(taggedCnt),
    .full(full), .empty(empty), .cmd(cmd), .statusByte(statusByte), .thrIrq(thrIrq)
  );

  assign statusWord = {24'h0, statusByte};

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R2
endmodule

// File: tb/tb_uart_line_status.sv
module tb_uart_line_status;
  logic        clk = 0, rstN = 0;
  logic        rxPush = 0, rxParErr = 0, rxFrmErr = 0, rxPop = 0;
  logic [7:0]  rxData = 0, rxDataOut;
  logic        rxLine = 1, bitTick = 0;
  logic [1:0]  cfgDataLen = 2'd3;
  logic        cfgParityEn = 0, cfgStop2 = 0;
  logic        txFifoEmpty = 1, txShiftEmpty = 1, txLastMove = 0, thrWrite = 0;
  logic        ierThreEn = 0, statusRead = 0;
  logic [31:0] statusWord;
  logic        thrIrq;
  int          nChecks = 0, nFails = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  uart_line_status dut (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxPop(rxPop), .rxDataOut(rxDataOut), .rxLine(rxLine),
    .bitTick(bitTick), .cfgDataLen(cfgDataLen), .cfgParityEn(cfgParityEn),
    .cfgStop2(cfgStop2), .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty),
    .txLastMove(txLastMove), .thrWrite(thrWrite), .ierThreEn(ierThreEn),
    .statusRead(statusRead), .statusWord(statusWord), .thrIrq(thrIrq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pushChar(logic [7:0] d, logic p, logic f);
    rxPush = 1; rxData = d; rxParErr = p; rxFrmErr = f;
    step();
    rxPush = 0; rxParErr = 0; rxFrmErr = 0;
  endtask

  task automatic popChar(output logic [7:0] d);
    d = rxDataOut; rxPop = 1; step(); rxPop = 0;
  endtask

  task automatic readStatus(output logic [31:0] s);
    s = statusWord; statusRead = 1; step(); statusRead = 0;
  endtask

  task automatic tick();
    bitTick = 1; step(); bitTick = 0; step();
  endtask

  task automatic testReset();
    check("R1 reset word", statusWord, 32'h60);
    check("R11 irq disabled", {31'b0, thrIrq}, 0);
    ierThreEn = 1; #1;
    check("R11 irq enabled", {31'b0, thrIrq}, 1);
  endtask

  task automatic testTx();
    thrWrite = 1; txFifoEmpty = 0; txShiftEmpty = 0; step(); thrWrite = 0;
    check("R10 thre cleared by write", statusWord, 32'h00);
    check("R11 irq low", {31'b0, thrIrq}, 0);
    txFifoEmpty = 1; #1;
    check("R9 shift busy", statusWord[6], 0);
    txLastMove = 1; thrWrite = 1; step(); txLastMove = 0; thrWrite = 0;
    check("R10 write wins", statusWord[5], 0);
    txLastMove = 1; step(); txLastMove = 0;
    check("R10 thre set", statusWord, 32'h20);
    check("R11 irq high", {31'b0, thrIrq}, 1);
    txShiftEmpty = 1; #1;
    check("R9 both empty", statusWord, 32'h60);
  endtask

  task automatic testFifoOrder();
    logic [7:0] d;
    pushChar(8'hA1, 0, 0); pushChar(8'hB2, 0, 0); pushChar(8'hC3, 0, 0);
    check("R2 data ready", statusWord, 32'h61);
    popChar(d); check("R2 order 0", {24'b0, d}, 32'hA1);
    popChar(d); check("R2 order 1", {24'b0, d}, 32'hB2);
    popChar(d); check("R2 order 2", {24'b0, d}, 32'hC3);
    check("R2 empty", statusWord[0], 0);
  endtask

  task automatic testTags();
    logic [31:0] s; logic [7:0] d;
    pushChar(8'h11, 0, 0); pushChar(8'h22, 1, 0); pushChar(8'h33, 0, 1);
    readStatus(s);
    check("R3 summary set, R4 clean head", s, 32'hE1);
    popChar(d);
    check("R4 parity at head", statusWord, 32'hE5);
    readStatus(s);
    check("R4 parity hidden after read", statusWord, 32'hE1);
    check("R3 summary survives read", statusWord[7], 1);
    popChar(d);
    check("R4 framing at head", statusWord, 32'hE9);
    popChar(d);
    check("R3 summary sticky when drained", statusWord, 32'hE0);
    readStatus(s);
    check("R3 summary cleared", statusWord, 32'h60);
  endtask

  task automatic testOverrun();
    logic [31:0] s; logic [7:0] d;
    for (int i = 0; i < 16; i++) pushChar(8'(i + 8'h40), 0, 0);
    check("R5 full no overrun", statusWord, 32'h61);
    pushChar(8'hEE, 0, 0);
    readStatus(s);
    check("R5 overrun flagged", s, 32'h63);
    check("R5 overrun cleared", statusWord, 32'h61);
    for (int i = 0; i < 16; i++) begin
      popChar(d);
      if (i == 0 || i == 15) check("R5 kept entries", {24'b0, d}, 32'(i + 8'h40));
    end
    check("R5 dropped char absent", statusWord[0], 0);
  endtask

  task automatic testBreak();
    logic [31:0] s; logic [7:0] d;
    cfgDataLen = 2'd3; cfgParityEn = 0; cfgStop2 = 0; // 10 ticks
    rxLine = 0; step();
    for (int i = 0; i < 10; i++) tick();
    check("R6 no break at char time", statusWord, 32'h60);
    tick();
    check("R6 break detected", statusWord, 32'hF1);
    for (int i = 0; i < 3; i++) tick();
    readStatus(s);
    check("R7 single break entry", s, 32'hF1);
    check("R6 break cleared by read", statusWord, 32'hE1);
    popChar(d);
    check("R6 break char zero", {24'b0, d}, 0);
    check("R7 no second entry", statusWord, 32'hE0);
    readStatus(s);
    rxLine = 1; cfgDataLen = 2'd0; cfgParityEn = 1; cfgStop2 = 1; step(); // 9 ticks
    rxLine = 0; step();
    for (int i = 0; i < 9; i++) tick();
    check("R8 short frame no break", statusWord[0], 0);
    tick();
    check("R8 R7 rearmed break", statusWord, 32'hF1);
    popChar(d); readStatus(s);
    check("R3 clean after break", statusWord, 32'h60);
    rxLine = 1; step();
  endtask

  initial begin
    repeat (3) step();
    rstN = 1; step();
    testReset();
    testTx();
    testFifoOrder();
    testTags();
    testOverrun();
    testBreak();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule